// File: doc/BRIEF.md
# Ethernet Transmit Status Tracker

This block follows a single packet through a half-duplex Ethernet transmitter and produces a one-byte status word describing how that packet ended. It listens to a start pulse and an end pulse that frame the packet, a pulse for every byte put on the wire, a collision pulse, the carrier-sense level and a FIFO-underflow pulse. Every collision is classed as one of three kinds: one that is worth another attempt, one that exceeds the attempt budget, or one that arrives too late in the frame to be retried. The block then requests a retry or aborts the packet.

When the packet ends, either normally or by abort, the status byte is latched and stays readable until the next packet starts. One-cycle interrupt pulses report transmit errors and FIFO underflow. All inputs and outputs are plain control and status pins. There is no data stream, so there is no valid/ready handshake. Every output is registered and changes one clock after the input event that causes it. Backoff timing, framing and the MII datapath are handled by neighbouring logic.

Top module: `tx_status_tracker`

## Requirements
- R1: After reset the status byte is 00h and retry_req, abort_o, pkt_done, tx_err_irq and fifo_irq are all low.
- R2: A collision during an active packet, before the byte window is reached, with the collision count below 15, adds one to the count in status bits 3:0 (bit 0 is the LSB). It also pulses retry_req for one cycle, in the cycle after the collision.
- R3: The byte counter restarts from zero on every retry. A collision becomes late only when 64 bytes have been counted in the current attempt before the collision cycle. A collision in the same cycle as the 64th byte is still in the window.
- R4: A collision while the count is already 15 aborts the packet. The result is a status of 8Fh (bit 7 set, count 1111), an abort_o pulse and a tx_err_irq pulse, with no retry_req.
- R5: A late collision aborts the packet without a retry. It sets status bit 6 and bit 7, leaves the count unchanged, and pulses tx_err_irq.
- R6: A falling edge of carrier sense during an active packet sets status bit 4 and bit 7 at completion, and pulses tx_err_irq.
- R7: An underflow pulse during an active packet pulses fifo_irq in the next cycle. It sets status bits 5 and 7 at completion and does not end the packet.
- R8: A packet that ends with pkt_end and has no error latches a status equal to its collision count with bits 7:4 clear. It pulses pkt_done without tx_err_irq.
- R9: The status byte reads 00h from the cycle after pkt_start until the packet completes or aborts. Retries do not clear it. It holds the latched value until the next pkt_start.
- R10: Collision, byte, underflow, carrier and end events while no packet is active have no effect on any output.
- R11: When a collision and pkt_end arrive in the same cycle, the collision is handled (retry or abort) and the end pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Pulse: a new packet begins |
| pkt_end | input | 1 | Pulse: the packet finished transmission |
| byte_sent | input | 1 | Pulse: one byte went out |
| coll_det | input | 1 | Pulse: collision detected |
| crs | input | 1 | Carrier-sense level |
| fifo_uflow | input | 1 | Pulse: transmit FIFO underflow |
| retry_req | output | 1 | Pulse: retransmit the packet |
| abort_o | output | 1 | Pulse: packet aborted |
| pkt_done | output | 1 | Pulse: packet completed normally |
| status_q | output | 8 | Status byte: 7 error, 6 late collision, 5 underflow, 4 carrier lost, 3:0 collision count |
| tx_err_irq | output | 1 | Pulse: transmit error on completion or abort |
| fifo_irq | output | 1 | Pulse: FIFO underflow seen |

## Verification
A wrong collision count only shows at the ports when the packet ends, in the latched low nibble. So the bench runs packets with zero, two and fifteen collisions, and with sixteen, which reaches the abort. A byte counter that is not cleared on retry shows up later: the collision after the next 63 bytes becomes a late abort instead of a retry, one cycle after that collision. A sticky error flag that is not cleared shows up in bit 7 and tx_err_irq of the following clean packet.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  localparam int COLL_W = 4;

  typedef struct packed {
    logic              terr;
    logic              owc;
    logic              uflow;
    logic              crs_lost;
    logic [COLL_W-1:0] coll_cnt;
  } tx_stat_t;
endpackage

// File: rtl/tx_byte_window.sv
module tx_byte_window #(
  parameter int WINDOW_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic late
);
  localparam int CW = $clog2(WINDOW_BYTES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW_BYTES);

  logic [CW-1:0] cnt;

  assign late = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (inc && !late) cnt <= cnt + 1'b1;
  end

  assert_win_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);
  assert_win_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !late);
endmodule

// File: rtl/tx_coll_ctrl.sv
module tx_coll_ctrl
  import tx_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              coll_ev,
  input  logic              late,
  output logic [COLL_W-1:0] cnt,
  output logic              retry_hit,
  output logic              exc_hit,
  output logic              owc_hit
);
  localparam logic [COLL_W-1:0] CNT_MAX = '1;

  always_comb begin
    owc_hit   = coll_ev && late;
    exc_hit   = coll_ev && !late && (cnt == CNT_MAX);
    retry_hit = coll_ev && !late && (cnt != CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (retry_hit) cnt <= cnt + 1'b1;
  end

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && retry_hit) |=> cnt == $past(cnt) + COLL_W'(1));
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !retry_hit) |=> $stable(cnt));
  assert_one_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_hit, exc_hit, owc_hit}));
endmodule

// File: rtl/tx_err_flags.sv
module tx_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic live,
  input  logic crs,
  input  logic uflow,
  output logic crs_lost_q,
  output logic uf_q,
  output logic crs_hit,
  output logic uf_hit
);
  logic crs_d;

  assign crs_hit = live && crs_d && !crs;
  assign uf_hit  = live && uflow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs_d      <= 1'b0;
      crs_lost_q <= 1'b0;
      uf_q       <= 1'b0;
    end else begin
      crs_d <= crs;
      if (clr) begin
        crs_lost_q <= 1'b0;
        uf_q       <= 1'b0;
      end else begin
        if (crs_hit) crs_lost_q <= 1'b1;
        if (uf_hit)  uf_q       <= 1'b1;
      end
    end
  end

  assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && !clr) |=> uf_q);
  assert_crs_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_lost_q && !clr) |=> crs_lost_q);
endmodule

// File: rtl/tx_status_tracker.sv
module tx_status_tracker
  import tx_stat_pkg::*;
#(
  parameter int WINDOW_BYTES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_start,
  input  logic       pkt_end,
  input  logic       byte_sent,
  input  logic       coll_det,
  input  logic       crs,
  input  logic       fifo_uflow,
  output logic       retry_req,
  output logic       abort_o,
  output logic       pkt_done,
  output logic [7:0] status_q,
  output logic       tx_err_irq,
  output logic       fifo_irq
);
  logic              active;
  logic              live;
  logic              coll_ev;
  logic              late;
  logic [COLL_W-1:0] coll_cnt;
  logic              retry_hit, exc_hit, owc_hit;
  logic              crs_lost_q, uf_q, crs_hit, uf_hit;
  logic              abort_hit, finish;
  tx_stat_t          next_stat;

  assign live      = active && !pkt_start;
  assign coll_ev   = live && coll_det;
  assign abort_hit = exc_hit || owc_hit;
  assign finish    = live && pkt_end && !coll_ev;

  tx_byte_window #(.WINDOW_BYTES(WINDOW_BYTES)) u_window (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pkt_start || retry_hit),
    .inc  (live && byte_sent),
    .late (late)
  );

  tx_coll_ctrl u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pkt_start),
    .coll_ev  (coll_ev),
    .late     (late),
    .cnt      (coll_cnt),
    .retry_hit(retry_hit),
    .exc_hit  (exc_hit),
    .owc_hit  (owc_hit)
  );

  tx_err_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pkt_start),
    .live      (live),
    .crs       (crs),
    .uflow     (fifo_uflow),
    .crs_lost_q(crs_lost_q),
    .uf_q      (uf_q),
    .crs_hit   (crs_hit),
    .uf_hit    (uf_hit)
  );

  always_comb begin
    next_stat.coll_cnt = coll_cnt;
    next_stat.crs_lost = crs_lost_q || crs_hit;
    next_stat.uflow    = uf_q || uf_hit;
    next_stat.owc      = owc_hit;
    next_stat.terr     = exc_hit || owc_hit || next_stat.crs_lost || next_stat.uflow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      status_q   <= 8'h00;
      retry_req  <= 1'b0;
      abort_o    <= 1'b0;
      pkt_done   <= 1'b0;
      tx_err_irq <= 1'b0;
      fifo_irq   <= 1'b0;
    end else begin
      retry_req  <= retry_hit;
      abort_o    <= abort_hit;
      pkt_done   <= finish;
      fifo_irq   <= uf_hit;
      tx_err_irq <= (abort_hit || finish) && next_stat.terr;
      if (pkt_start) begin
        active   <= 1'b1;
        status_q <= 8'h00;
      end else if (abort_hit || finish) begin
        active   <= 1'b0;
        status_q <= next_stat;
      end
    end
  end

  assert_retry_abort_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_req && abort_o));
  assert_done_abort_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done && abort_o));
  assert_summary_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[6:4] != 3'b000) |-> status_q[7]);
  assert_fifo_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_irq |-> $past(fifo_uflow));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !pkt_start) |=> !retry_req && !abort_o && !pkt_done);
  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_start && !abort_hit && !finish) |=> $stable(status_q));
endmodule

// File: tb/test_tx_status_tracker.sv
module test_tx_status_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 0, pkt_end = 0, byte_sent = 0, coll_det = 0, crs = 0, fifo_uflow = 0;
  logic retry_req, abort_o, pkt_done, tx_err_irq, fifo_irq;
  logic [7:0] status_q;

  typedef struct {
    logic [7:0] st;
    logic       ab;
    logic       tei;
  } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_status_tracker i_tx_status_tracker (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .byte_sent(byte_sent), .coll_det(coll_det), .crs(crs), .fifo_uflow(fifo_uflow),
    .retry_req(retry_req), .abort_o(abort_o), .pkt_done(pkt_done),
    .status_q(status_q), .tx_err_irq(tx_err_irq), .fifo_irq(fifo_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic start_pkt();
    pkt_start = 1; step(); pkt_start = 0;
    chk("R9 status cleared at start", status_q, 8'h00);
  endtask

  task automatic send_bytes(int n);
    for (int i = 0; i < n; i++) begin
      byte_sent = 1; step(); byte_sent = 0;
    end
  endtask

  task automatic coll_retry(string req);
    coll_det = 1; step(); coll_det = 0;
    chk({req, " retry_req"}, retry_req, 1);
    chk({req, " no abort"}, abort_o, 0);
  endtask

  task automatic coll_abort(logic [7:0] st);
    exp_t e;
    e.st = st; e.ab = 1; e.tei = 1;
    exp_q.push_back(e);
    coll_det = 1; step(); coll_det = 0;
    chk("R5 no retry on abort", retry_req, 0);
  endtask

  task automatic end_pkt(logic [7:0] st, logic tei);
    exp_t e;
    e.st = st; e.ab = 0; e.tei = tei;
    exp_q.push_back(e);
    pkt_end = 1; step(); pkt_end = 0;
  endtask

  // monitor: pops expected items when the design reports an outcome
  always @(negedge clk) begin
    if (rst_n && (pkt_done || abort_o)) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected outcome actual=%0h expected=none", status_q);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (status_q !== e.st || abort_o !== e.ab || tx_err_irq !== e.tei) begin
          bad++;
          $display("FAIL R4/R5/R6/R7/R8 outcome actual=%0h/%0b/%0b expected=%0h/%0b/%0b",
                   status_q, abort_o, tx_err_irq, e.st, e.ab, e.tei);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1; crs = 1;
    step();
    // R1 reset state
    chk("R1 status", status_q, 8'h00);
    chk("R1 retry", retry_req, 0);
    chk("R1 abort", abort_o, 0);
    chk("R1 irqs", {pkt_done, tx_err_irq, fifo_irq}, 0);

    // R8 clean packet
    start_pkt(); send_bytes(10); end_pkt(8'h00, 0);
    chk("R8 done pulse", pkt_done, 1);

    // R2 two collisions, R9 status stays cleared across retry
    start_pkt(); send_bytes(5); coll_retry("R2 first");
    chk("R9 status held through retry", status_q, 8'h00);
    send_bytes(5); coll_retry("R2 second");
    end_pkt(8'h02, 0);
    chk("R9 latched value", status_q, 8'h02);
    step();
    chk("R9 hold after done", status_q, 8'h02);

    // R3 byte window restarts on retry; late collision aborts (R5)
    start_pkt(); send_bytes(63); coll_retry("R3 63 bytes in window");
    send_bytes(63); coll_retry("R3 counter restarted");
    send_bytes(64); coll_abort(8'hC2);
    chk("R5 abort pulse", abort_o, 1);
    chk("R5 tei", tx_err_irq, 1);

    // R3 collision in same cycle as 64th byte still retried
    start_pkt(); send_bytes(63);
    byte_sent = 1; coll_det = 1; step(); byte_sent = 0; coll_det = 0;
    chk("R3 boundary retry", retry_req, 1);
    end_pkt(8'h01, 0);

    // R4 excessive collisions
    start_pkt();
    for (int k = 0; k < 15; k++) begin
      send_bytes(2); coll_retry("R4 retry run");
    end
    coll_abort(8'h8F);
    chk("R4 abort", abort_o, 1);

    // R6 carrier loss
    start_pkt(); send_bytes(3); crs = 0; step(); crs = 1; send_bytes(2);
    end_pkt(8'h90, 1);

    // R7 underflow
    start_pkt(); send_bytes(2); fifo_uflow = 1; step(); fifo_uflow = 0;
    chk("R7 fifo_irq", fifo_irq, 1);
    chk("R7 not ended", abort_o | pkt_done, 0);
    step();
    chk("R7 fifo_irq single", fifo_irq, 0);
    end_pkt(8'hA0, 1);

    // R10 idle events ignored
    coll_det = 1; fifo_uflow = 1; byte_sent = 1; pkt_end = 1; crs = 0; step();
    coll_det = 0; fifo_uflow = 0; byte_sent = 0; pkt_end = 0; crs = 1;
    chk("R10 retry", retry_req, 0);
    chk("R10 abort/done", abort_o | pkt_done, 0);
    chk("R10 fifo_irq", fifo_irq, 0);
    chk("R10 tei", tx_err_irq, 0);
    chk("R10 status", status_q, 8'hA0);

    // R11 collision wins over end
    start_pkt(); send_bytes(4);
    coll_det = 1; pkt_end = 1; step(); coll_det = 0; pkt_end = 0;
    chk("R11 retry", retry_req, 1);
    chk("R11 no done", pkt_done, 0);
    end_pkt(8'h01, 0);

    step();
    chk("R8 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule